// File: doc/BRIEF.md
# Fault Injection Sequencing Controller

This block runs one fault injection on a design under test whose flops each carry a shadow select bit. The select bits form a serial chain. A 64-bit command names the target flop and the design cycle at which the fault is to strike. When the controller accepts a command, it holds the design clock off and shifts a pattern into the chain. The pattern has a single one, at the target position. The controller then lets the design run and counts design cycles until the programmed time is reached. At that point it holds the design clock once more and raises the injection enable for a fixed number of cycles. After that it releases the design to run freely and flags completion.

A flop ID outside the chain makes the command a null command. A null command shifts an all-zero pattern, so no select from an earlier run is left behind. It waits out the same number of cycles and never raises the injection enable. A host can therefore capture a fault-free reference run under the same timing as a faulty one. The controller takes a new command only while it is idle.

Top module: `flt_inject_seq`

## Requirements
- R1: After a synchronous active-high reset the controller is idle, with busy, done, scan_en, scan_data and inj_en low and dut_clk_en high.
- R2: A command is accepted only when cmd_valid is high while the controller is idle. A cmd_valid pulse during a run does not change that run's target, timing or pulse count.
- R3: Starting in the cycle after acceptance, scan_en is high for exactly CHAIN_LEN consecutive cycles. The bit on scan_data in shift step k (counting from 0) ends up at chain position CHAIN_LEN-1-k, so exactly one step carries a 1, and that 1 lands at the target flop ID.
- R4: dut_clk_en is low in every cycle where scan_en or inj_en is high, and high in every other cycle.
- R5: Between the last shift cycle and the first inj_en cycle there are exactly T cycles with dut_clk_en high, where T is the programmed injection time. T = 0 makes inj_en follow the shift directly.
- R6: For a valid target, inj_en is high for exactly INJ_CYCLES consecutive cycles per command.
- R7: dut_clk_en is high in the cycle right after the last inj_en cycle.
- R8: A flop ID of CHAIN_LEN or more is a null command. It shifts CHAIN_LEN zeros, never raises inj_en, and finishes after the same shift and wait cycles.
- R9: done is a one-cycle pulse in the cycle after the final inject cycle, or after the final wait cycle of a null command. busy is high from the cycle after acceptance through the done cycle and low in the cycle after done.
- R10: Command layout: bits [15:0] hold the target flop ID, and bits [63:16] hold the injection time T as an unsigned count of design cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, sampled only while idle |
| cmd_word | input | 64 | Injection command (ID in [15:0], time in [63:16]) |
| busy | output | 1 | A command is being sequenced |
| done | output | 1 | One-cycle completion pulse |
| dut_clk_en | output | 1 | Clock enable for the design under test |
| scan_en | output | 1 | Shift enable for the select chain |
| scan_data | output | 1 | Serial bit into the select chain |
| inj_en | output | 1 | Fault injection enable to the selected flop |

## Verification
The bench goes after the chain ends: ID 0, ID CHAIN_LEN-1, the first null ID at CHAIN_LEN, and the largest ID the field can hold. An off-by-one shift count or a reversed chain order would drop the single one at the wrong position or lose it off the end. It also runs T = 0 and T = 1. A wait counter that compares one step late or one step early would add or lose a design cycle before the strike. A null command must show no injection pulse and a cleared chain, which catches a design that still pulses or leaves the old select in place. A command strobe during a shift must not change the run, which catches a design that re-latches the command outside idle.

// File: rtl/fis_pkg.sv
package fis_pkg;

  localparam int CMD_W  = 64;
  localparam int ID_W   = 16;
  localparam int TIME_W = CMD_W - ID_W;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_INJECT = 3'd3,
    ST_DONE   = 3'd4
  } fis_state_e;

endpackage

// File: rtl/fis_cmd_decode.sv
module fis_cmd_decode
  import fis_pkg::*;
#(
  parameter int CHAIN_LEN = 24,
  localparam int SH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [SH_W-1:0]   hit_step,
  output logic [TIME_W-1:0] inj_time,
  output logic              is_null
);

  logic [ID_W-1:0] id_field;

  always_comb begin
    id_field = cmd_word[ID_W-1:0];
    inj_time = cmd_word[CMD_W-1:ID_W];
    is_null  = (id_field >= ID_W'(CHAIN_LEN));
    // The first bit shifted travels to the far end of the chain.
    hit_step = SH_W'(CHAIN_LEN - 1) - id_field[SH_W-1:0];
  end

endmodule

// File: rtl/fis_counter.sv
module fis_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + W'(1);
  end

endmodule

// File: rtl/flt_inject_seq.sv
module flt_inject_seq
  import fis_pkg::*;
#(
  parameter int CHAIN_LEN  = 24,
  parameter int INJ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             busy,
  output logic             done,
  output logic             dut_clk_en,
  output logic             scan_en,
  output logic             scan_data,
  output logic             inj_en
);

  localparam int SH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam int IC_W = (INJ_CYCLES > 1) ? $clog2(INJ_CYCLES) : 1;
  localparam logic [SH_W-1:0] LAST_SH  = SH_W'(CHAIN_LEN - 1);
  localparam logic [IC_W-1:0] LAST_INJ = IC_W'(INJ_CYCLES - 1);

  fis_state_e state_q, state_d;

  logic [SH_W-1:0]   dec_step, step_q;
  logic [TIME_W-1:0] dec_time, time_q;
  logic              dec_null, null_q;

  logic [SH_W-1:0]   sh_cnt;
  logic [TIME_W-1:0] wait_cnt;
  logic [IC_W-1:0]   inj_cnt;

  logic accept;
  logic sh_last, wait_last, inj_last;

  fis_cmd_decode #(.CHAIN_LEN(CHAIN_LEN)) u_dec (
    .cmd_word (cmd_word),
    .hit_step (dec_step),
    .inj_time (dec_time),
    .is_null  (dec_null)
  );

  fis_counter #(.W(SH_W)) u_sh_cnt (
    .clk (clk), .rst (rst),
    .clr (state_q != ST_SHIFT),
    .inc (state_q == ST_SHIFT),
    .q   (sh_cnt)
  );

  fis_counter #(.W(TIME_W)) u_wait_cnt (
    .clk (clk), .rst (rst),
    .clr (state_q != ST_WAIT),
    .inc (state_q == ST_WAIT),
    .q   (wait_cnt)
  );

  fis_counter #(.W(IC_W)) u_inj_cnt (
    .clk (clk), .rst (rst),
    .clr (state_q != ST_INJECT),
    .inc (state_q == ST_INJECT),
    .q   (inj_cnt)
  );

  assign accept    = (state_q == ST_IDLE) && cmd_valid;
  assign sh_last   = (sh_cnt == LAST_SH);
  assign wait_last = (wait_cnt == time_q - TIME_W'(1));
  assign inj_last  = (inj_cnt == LAST_INJ);

  // Command latch: only written on acceptance in idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      time_q <= '0;
      null_q <= 1'b1;
    end else if (accept) begin
      step_q <= dec_step;
      time_q <= dec_time;
      null_q <= dec_null;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_valid) state_d = ST_SHIFT;
      ST_SHIFT:
        if (sh_last) begin
          if (time_q != '0) state_d = ST_WAIT;
          else if (null_q)  state_d = ST_DONE;
          else              state_d = ST_INJECT;
        end
      ST_WAIT:
        if (wait_last) state_d = null_q ? ST_DONE : ST_INJECT;
      ST_INJECT: if (inj_last) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Moore decode of the registered state and counters.
  always_comb begin
    busy       = (state_q != ST_IDLE);
    done       = (state_q == ST_DONE);
    scan_en    = (state_q == ST_SHIFT);
    inj_en     = (state_q == ST_INJECT);
    scan_data  = scan_en && !null_q && (sh_cnt == step_q);
    dut_clk_en = !(scan_en || inj_en);
  end

endmodule

// File: rtl/fis_checker.sv
module fis_checker #(
  parameter int CHAIN_LEN  = 24,
  parameter int INJ_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic dut_clk_en,
  input logic scan_en,
  input logic scan_data,
  input logic inj_en
);

  int scan_run, ones_run, inj_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_run <= 0;
      ones_run <= 0;
      inj_run  <= 0;
    end else begin
      scan_run <= scan_en ? scan_run + 1 : 0;
      ones_run <= scan_en ? ones_run + int'(scan_data) : 0;
      inj_run  <= inj_en ? inj_run + 1 : 0;
    end
  end

  AST_SCAN_GATED: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> !dut_clk_en); // R4
  AST_INJ_GATED: assert property (@(posedge clk) disable iff (rst)
    inj_en |-> !dut_clk_en); // R4
  AST_CLK_FREE: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !inj_en) |-> dut_clk_en); // R4
  AST_SHIFT_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> (scan_run == CHAIN_LEN)); // R3
  AST_ONE_HOT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> (ones_run <= 1)); // R3
  AST_DATA_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    scan_data |-> scan_en); // R3
  AST_INJ_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(inj_en) |-> (inj_run == INJ_CYCLES)); // R6
  AST_CLK_AFTER_INJ: assert property (@(posedge clk) disable iff (rst)
    $fell(inj_en) |-> dut_clk_en); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scan_en && !inj_en && !done)); // R2

endmodule

bind flt_inject_seq fis_checker #(
  .CHAIN_LEN  (CHAIN_LEN),
  .INJ_CYCLES (INJ_CYCLES)
) u_fis_checker (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .dut_clk_en (dut_clk_en),
  .scan_en    (scan_en),
  .scan_data  (scan_data),
  .inj_en     (inj_en)
);

// File: tb/flt_inject_seq_test.sv
`timescale 1ns/1ps
module flt_inject_seq_test;

  localparam int L   = 24;
  localparam int NIC = 2;

  typedef struct packed {
    logic [63:0] cmd;
    logic [7:0]  pos;   // 255 marks a null command
    logic [7:0]  waits;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{{48'd5,  16'd0},     8'd0,   8'd5},
    '{{48'd0,  16'd23},    8'd23,  8'd0},
    '{{48'd1,  16'd7},     8'd7,   8'd1},
    '{{48'd30, 16'd12},    8'd12,  8'd30},
    '{{48'd3,  16'd24},    8'd255, 8'd3},
    '{{48'd2,  16'hFFFF},  8'd255, 8'd2},
    '{{48'd9,  16'd3},     8'd3,   8'd9}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [63:0] cmd_word = '0;
  logic busy, done, dut_clk_en, scan_en, scan_data, inj_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flt_inject_seq #(.CHAIN_LEN(L), .INJ_CYCLES(NIC)) uut (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
    .busy (busy), .done (done), .dut_clk_en (dut_clk_en),
    .scan_en (scan_en), .scan_data (scan_data), .inj_en (inj_en)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] cmd, input int pos, input int waits,
                         input bit intrude, input string tag);
    logic [L-1:0] chain = '0;
    logic [L-1:0] exp_chain;
    int sc = 0, wc = 0, ic = 0, gate_bad = 0, order_bad = 0;
    bit seen_done = 1'b0;
    exp_chain = (pos == 255) ? '0 : (L'(1) << pos);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = cmd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, {"R9 busy after accept ", tag}, busy, 1);
    for (int i = 0; i < 2000; i++) begin
      if (done) begin
        seen_done = 1'b1;
        check(dut_clk_en == 1'b1, {"R7 clock after inject ", tag}, dut_clk_en, 1);
        break;
      end
      if (scan_en) begin
        chain = {chain[L-2:0], scan_data};
        sc++;
        if (dut_clk_en || wc > 0 || ic > 0) gate_bad++;
      end else if (inj_en) begin
        ic++;
        if (dut_clk_en) gate_bad++;
      end else begin
        wc++;
        if (!dut_clk_en) gate_bad++;
        if (ic > 0) order_bad++;
      end
      if (intrude && i == 2) begin
        cmd_valid = 1'b1;
        cmd_word  = {48'd0, 16'd10};
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(seen_done, {"R9 done seen ", tag}, seen_done, 1);
    check(sc == L, {"R3 shift length ", tag}, sc, L);
    check(chain == exp_chain, {"R3 R8 R10 chain contents ", tag}, chain, exp_chain);
    check(wc == waits, {"R5 wait cycles ", tag}, wc, waits);
    check(ic == ((pos == 255) ? 0 : NIC), {"R6 R8 inject cycles ", tag}, ic,
          (pos == 255) ? 0 : NIC);
    check(gate_bad == 0 && order_bad == 0, {"R4 gating and order ", tag},
          gate_bad + order_bad, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, {"R9 idle after done ", tag},
          {done, busy}, 0);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, done, scan_en, scan_data, inj_en} == 5'b0, "R1 outputs in reset",
          {busy, done, scan_en, scan_data, inj_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && dut_clk_en == 1'b1, "R1 idle after reset",
          {busy, dut_clk_en}, 1);
    // R2: no command, no activity
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && scan_en == 1'b0, "R2 idle without strobe", {busy, scan_en}, 0);

    for (int v = 0; v < NV; v++) begin
      run_one(VECS[v].cmd, int'(VECS[v].pos), int'(VECS[v].waits), 1'b0,
              $sformatf("vec%0d", v));
    end

    // R2: a strobe during the shift is ignored
    run_one({48'd6, 16'd4}, 4, 6, 1'b1, "R2 strobe while busy");

    // R8 then normal: null run leaves no select behind
    run_one({48'd0, 16'd100}, 255, 0, 1'b0, "R8 null zero time");
    run_one({48'd1, 16'd22}, 22, 1, 1'b0, "after null");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule